// File: doc/BRIEF.md
# Systolic insertion sorter array

The block sorts short blocks of 128-bit keys with a linear chain of identical compare cells. A key arrives on every clock as a 64-bit high word and a 64-bit low word, the high word being the more significant. Each cell keeps the largest key it has received so far. It passes the smaller of its held key and the arriving key one cell further down on the next clock. An empty cell simply captures the first key that reaches it. A stall-free stream of up to N keys therefore ends up spread over the chain in descending order, starting at the head cell.

A flag on the final key of a block closes that block. The chain then waits for the last comparison wave to travel to the tail. After that it shifts its contents toward the head, so the results leave largest first on a result stream qualified by a valid signal. Once the drain is complete every cell is empty again and the next block may start. Feeding one block after another in this way turns a long list into many independently sorted lists. Merging those lists is left to other logic.

Top module: `sys_insert_sorter`

## Requirements
- R1: Keys are compared as unsigned 128-bit values formed as {in_hi, in_lo}, so any difference in the high word decides the order before the low word is looked at.
- R2: While the array is accepting, a key is taken on every clock edge where in_valid is high, with no stall. Clocks with in_valid low inside a block add nothing and do not disturb the keys already taken.
- R3: For a block of L keys with 1 <= L <= N, exactly L results appear on out_hi/out_lo. They come in non-increasing order and form the same multiset as the input.
- R4: When the edge that takes the key carrying in_last is edge c, the k-th result (k counted from 0) is valid for the clock after edge c+N+k. Results of one block come on consecutive clocks, and the whole block has left by edge c+2N-1.
- R5: out_valid is high only for results. During the drain of a block shorter than N it stays low once the block's keys have left.
- R6: Keys presented on edges c+1 through c+2N-1 are dropped, whatever their value and in_last. The key presented on edge c+2N is the first key of the next block.
- R7: For a block longer than N, the results are the N largest keys of the block in non-increasing order. The remaining keys are discarded.
- R8: A synchronous active-high reset empties every cell, drops a partly received block and holds out_valid low in the cycle after the reset edge.
- R9: Equal keys are all kept. A block holding repeated values returns each copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A key is present on in_hi/in_lo |
| in_last | input | 1 | The present key closes the block |
| in_hi | input | WORD | More significant half of the key |
| in_lo | input | WORD | Less significant half of the key |
| out_valid | output | 1 | out_hi/out_lo carry a sorted result |
| out_hi | output | WORD | More significant half of the result |
| out_lo | output | WORD | Less significant half of the result |

## Verification
Two functions can fall into the same clock: the drain shifting results toward the head, and an input key arriving that must be dropped. A second collision is the final drain edge, followed on the very next edge by the first key of a new block. Both are provoked by presenting all-ones keys, the largest possible value, on every clock from one edge after the last key up to edge c+2N-1, sometimes with in_last raised. A real block follows with no gap, so its first key is taken on edge c+2N. The outcome is judged at the result stream. A single accepted all-ones key would surface as an extra or out-of-order result, and a lost first key would shorten the second block's result count.

// File: rtl/sis_pkg.sv
package sis_pkg;

   typedef enum logic [1:0] {
      PH_FILL   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_DRAIN  = 2'd2
   } phase_t;

endpackage

// File: rtl/sis_cell.sv
module sis_cell #(
   parameter int KW = 128
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          drain,
   input  logic          in_v,
   input  logic [KW-1:0] in_k,
   input  logic          nx_v,
   input  logic [KW-1:0] nx_k,
   output logic          hd_v,
   output logic [KW-1:0] hd_k,
   output logic          fw_v,
   output logic [KW-1:0] fw_k
);

   logic beats;

   // strict compare: a tie keeps the held key and forwards the newcomer
   assign beats = in_k > hd_k;

   always_ff @(posedge clk) begin
      if (rst) begin
         hd_v <= 1'b0;
         fw_v <= 1'b0;
      end else if (drain) begin
         hd_v <= nx_v;
         hd_k <= nx_k;
         fw_v <= 1'b0;
      end else begin
         fw_v <= in_v && hd_v;
         if (in_v) begin
            if (!hd_v || beats) begin
               hd_v <= 1'b1;
               hd_k <= in_k;
            end
            if (beats) fw_k <= hd_k;
            else       fw_k <= in_k;
         end
      end
   end

endmodule

// File: rtl/sis_ctrl.sv
module sis_ctrl
   import sis_pkg::*;
#(
   parameter int N = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_last,
   output logic accept,
   output logic drain
);

   localparam int CW = $clog2(N) + 1;

   phase_t        phase;
   logic [CW-1:0] cnt;

   assign accept = (phase == PH_FILL);
   assign drain  = (phase == PH_DRAIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_FILL;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_FILL: begin
               if (in_valid && in_last) begin
                  phase <= PH_SETTLE;
                  cnt   <= '0;
               end
            end
            PH_SETTLE: begin
               if (cnt == CW'(N - 2)) begin
                  phase <= PH_DRAIN;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DRAIN: begin
               if (cnt == CW'(N - 1)) begin
                  phase <= PH_FILL;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               phase <= PH_FILL;
               cnt   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sys_insert_sorter.sv
module sys_insert_sorter #(
   parameter int N    = 16,
   parameter int WORD = 64
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic            in_last,
   input  logic [WORD-1:0] in_hi,
   input  logic [WORD-1:0] in_lo,
   output logic            out_valid,
   output logic [WORD-1:0] out_hi,
   output logic [WORD-1:0] out_lo
);

   localparam int KW = 2 * WORD;

   if (N < 2) begin : g_bad_n
      $error("sys_insert_sorter: N must be at least 2");
   end
   if (WORD < 1) begin : g_bad_word
      $error("sys_insert_sorter: WORD must be at least 1");
   end

   logic          accept;
   logic          drain;
   logic          take;

   logic [N:0]    link_v;
   logic [KW-1:0] link_k [N+1];
   logic [N-1:0]  cell_v;
   logic [KW-1:0] cell_k [N];
   logic [KW-1:0] res_k;

   assign take      = in_valid && accept;
   assign link_v[0] = take;
   assign link_k[0] = {in_hi, in_lo};

   sis_ctrl #(.N(N)) i_ctrl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (take),
      .in_last  (in_last),
      .accept   (accept),
      .drain    (drain)
   );

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic          nv;
      logic [KW-1:0] nk;

      if (i == N - 1) begin : g_tail
         assign nv = 1'b0;
         assign nk = '0;
      end else begin : g_body
         assign nv = cell_v[i+1];
         assign nk = cell_k[i+1];
      end

      sis_cell #(.KW(KW)) i_cell (
         .clk   (clk),
         .rst   (rst),
         .drain (drain),
         .in_v  (link_v[i]),
         .in_k  (link_k[i]),
         .nx_v  (nv),
         .nx_k  (nk),
         .hd_v  (cell_v[i]),
         .hd_k  (cell_k[i]),
         .fw_v  (link_v[i+1]),
         .fw_k  (link_k[i+1])
      );
   end

   // keys falling off the tail belong to an over-long block and are dropped
   logic unused_tail;
   assign unused_tail = ^{link_v[N], link_k[N]};

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= drain && cell_v[0];
         if (drain) res_k <= cell_k[0];
      end
   end

   assign out_hi = res_k[KW-1:WORD];
   assign out_lo = res_k[WORD-1:0];

endmodule

// File: rtl/sis_chk.sv
module sis_chk #(
   parameter int N    = 16,
   parameter int WORD = 64
) (
   input logic            clk,
   input logic            rst,
   input logic            drain,
   input logic [N-1:0]    cell_v,
   input logic            out_valid,
   input logic [WORD-1:0] out_hi,
   input logic [WORD-1:0] out_lo
);

   // R3: consecutive results never increase
   p_desc_order_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(out_valid)) |->
         ({out_hi, out_lo} <= {$past(out_hi), $past(out_lo)}));

   // R3: occupied cells always form a run starting at the head
   p_prefix_r3: assert property (@(posedge clk) disable iff (rst)
      (cell_v & (cell_v + N'(1))) == {N{1'b0}});

   // R5: a result only follows a drain cycle
   p_out_in_drain_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(drain));

   // R6: leaving the drain phase finds every cell empty despite input
   p_empty_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(drain) && !drain) |-> (cell_v == {N{1'b0}}));

   // R8: nothing is presented right after a reset edge
   p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && cell_v == {N{1'b0}}));

endmodule

bind sys_insert_sorter sis_chk #(.N(N), .WORD(WORD)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .drain     (drain),
   .cell_v    (cell_v),
   .out_valid (out_valid),
   .out_hi    (out_hi),
   .out_lo    (out_lo)
);

// File: tb/test_sys_insert_sorter.sv
module test_sys_insert_sorter;

   localparam int N  = 16;
   localparam int W  = 64;
   localparam int KW = 2 * W;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_last  = 1'b0;
   logic [W-1:0]  in_hi = '0;
   logic [W-1:0]  in_lo = '0;
   logic          out_valid;
   logic [W-1:0]  out_hi;
   logic [W-1:0]  out_lo;

   sys_insert_sorter #(.N(N), .WORD(W)) i_sys_insert_sorter (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_hi     (in_hi),
      .in_lo     (in_lo),
      .out_valid (out_valid),
      .out_hi    (out_hi),
      .out_lo    (out_lo)
   );

   always #2 clk = ~clk;   // 250 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;
   string cur_req = "R3";

   logic [KW-1:0] eq_k [$];
   int            eq_c [$];
   logic [KW-1:0] blk [64];
   logic [63:0]   seed = 64'h0123_4567_89ab_cdef;

   task automatic check(input bit ok, input string req,
                        input logic [KW-1:0] act, input logic [KW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] rnd();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed ^ (seed >> 29);
   endfunction

   // monitor: every result is matched against the expected key and clock
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (eq_k.size() == 0) begin
            check(1'b0, "R5 unexpected result", {out_hi, out_lo}, '0);
         end else begin
            logic [KW-1:0] ek;
            int            ec;
            ek = eq_k.pop_front();
            ec = eq_c.pop_front();
            check({out_hi, out_lo} == ek, cur_req, {out_hi, out_lo}, ek);
            check(cyc == ec, "R4 result clock", KW'(cyc), KW'(ec));
         end
      end
   end

   // modes: 0 random, 1 equal high words (R1), 2 ascending, 3 repeats (R9),
   // 4 high word 0 or 1 against random low words (R1), 5 descending
   task automatic build(input int mode, input int len);
      for (int i = 0; i < len; i++) begin
         logic [63:0] a, b;
         a = rnd();
         b = rnd();
         case (mode)
            0: blk[i] = {a, b};
            1: blk[i] = {64'h5a5a_0000_1234_ffff, b};
            2: blk[i] = {64'(i + 1), b};
            3: blk[i] = {64'(a % 3), 64'(b % 2)};
            4: blk[i] = {64'(a & 64'd1), b};
            default: blk[i] = {64'(200 - i), b};
         endcase
      end
   endtask

   task automatic expect_block(input int len, input int c);
      logic [KW-1:0] s [64];
      int m;
      for (int i = 0; i < len; i++) s[i] = blk[i];
      for (int i = 1; i < len; i++) begin
         logic [KW-1:0] t;
         int j;
         t = s[i];
         j = i - 1;
         while (j >= 0 && s[j] < t) begin
            s[j+1] = s[j];
            j--;
         end
         s[j+1] = t;
      end
      m = (len < N) ? len : N;
      for (int k = 0; k < m; k++) begin
         eq_k.push_back(s[k]);
         eq_c.push_back(c + N + k);
      end
   endtask

   task automatic send(input int len, input bit gap, input bit junk);
      int c;
      c = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         {in_hi, in_lo} = blk[i];
         in_last = (i == len - 1);
         if (i == len - 1) c = cyc + 1;
         if (gap && i < len - 1) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            {in_hi, in_lo} = '1;
         end
      end
      expect_block(len, c);
      if (junk) begin
         for (int j = 1; j < 2 * N; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_last  = (j % 3 == 0);
            {in_hi, in_lo} = '1;
         end
      end else begin
         @(negedge clk);
         in_valid = 1'b0;
         in_last  = 1'b0;
         repeat (2 * N) @(negedge clk);
         check(eq_k.size() == 0, "R4 block complete", KW'(eq_k.size()), '0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8 reset state", KW'(out_valid), '0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R8 idle after reset", KW'(out_valid), '0);

      // exhaustive sweep of block length for every key pattern
      for (int mode = 0; mode < 6; mode++) begin
         for (int len = 1; len <= N; len++) begin
            if (mode == 1 || mode == 4) cur_req = "R1";
            else if (mode == 3)         cur_req = "R9";
            else                        cur_req = "R3";
            build(mode, len);
            send(len, 1'b0, 1'b0);
         end
      end

      // R7: blocks longer than the chain keep the N largest
      cur_req = "R7";
      for (int mode = 0; mode < 6; mode++) begin
         for (int len = N + 1; len <= N + 5; len++) begin
            build(mode, len);
            send(len, 1'b0, 1'b0);
         end
      end

      // R2: bubbles between keys
      cur_req = "R2";
      for (int len = 2; len <= N; len += 7) begin
         build(0, len);
         send(len, 1'b1, 1'b0);
      end

      // R6: all-ones keys during settle and drain, next block on edge c+2N
      cur_req = "R6";
      for (int len = 1; len <= N; len += 5) begin
         build(0, len);
         send(len, 1'b0, 1'b1);
         build(2, N);
         send(N, 1'b0, 1'b0);
      end

      // R8: reset in the middle of a block drops it
      cur_req = "R8";
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_last  = 1'b0;
         {in_hi, in_lo} = '1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 during reset", KW'(out_valid), '0);
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 after reset", KW'(out_valid), '0);
      build(0, 7);
      send(7, 1'b0, 1'b0);

      repeat (4) @(negedge clk);
      check(eq_k.size() == 0, "R3 all results seen", KW'(eq_k.size()), '0);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule